// File: doc/BRIEF.md
# Dual-Threshold Overrange Clipper

This block guards two points of an oversampling converter's data path. One stream carries raw modulator samples at the sampling rate. The other carries the output of a filter stage. Each stream passes through a saturating clipper, and each clipper raises a trip when its input lies beyond its threshold.

The modulator threshold sits about 3% above full scale. It is computed as full scale plus full scale shifted right by five bits, so no multiplier is needed. The filter threshold is exactly full scale. Clipping is symmetric, so negative values saturate at the negated threshold.

The two trips are ORed into one overrange flag, which is updated on every falling clock edge. The modulator trip is delayed so that it shows up three and a half cycles after the rising edge that captured the sample. This matches the latency of the analog front end. The filter trip shows up half a cycle after its capture edge. The flag has no memory: it follows the detectors and is meant to be read while the clock is low.

Top module: `overrange_clip_pair`

## Requirements
- R1: While reset is low, both clipped outputs, both output valids and the overrange flag are 0.
- R2: A valid modulator sample whose value lies within plus or minus (FS + floor(FS/32)) appears unchanged on the clipped modulator output at the next rising edge, with its output valid set. With the default FS of 32767, the limit is 33790.
- R3: A valid modulator sample above +33790 is output as +33790, and one below -33790 is output as -33790. A value equal to the limit does not trip.
- R4: A valid filter sample within plus or minus FS passes unchanged at the next rising edge. Above +FS it is output as +FS, and below -FS it is output as -FS (so -32768 becomes -32767). A value equal to FS does not trip.
- R5: A tripping modulator sample captured at rising edge k sets the flag at the falling edge between edges k+3 and k+4. The flag is still low at the falling edge after k+2 and at edge k+3.
- R6: A tripping filter sample captured at rising edge j sets the flag at the falling edge right after j.
- R7: The flag is the OR of the delayed modulator trip and the filter trip, re-evaluated at every falling edge. It is not sticky and clears at the next falling edge once neither cause is present. A modulator trip keeps it high even when a valid in-range filter sample arrives in the same half cycle.
- R8: A sample presented with its valid low does not change that stream's clipped output, clears that output's valid, and does not raise the flag, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; captures on rising edge, flag updates on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_vld | input | 1 | Modulator sample valid |
| mod_dat | input | MOD_W (18) | Signed modulator sample |
| flt_vld | input | 1 | Filter sample valid |
| flt_dat | input | FLT_W (18) | Signed filter-stage sample |
| mod_clip_vld | output | 1 | Clipped modulator sample valid |
| mod_clip | output | MOD_W (18) | Clipped modulator sample |
| flt_clip_vld | output | 1 | Clipped filter sample valid |
| flt_clip | output | FLT_W (18) | Clipped filter sample |
| ovr_flag | output | 1 | Combined overrange flag, valid while clock is low |

## Verification
The bench drives values equal to each threshold and values one step beyond it, on both signs. A clipper that compares with `>=`, or that saturates only positive values, would then flag or alter a legal sample. For the modulator path it checks the flag at three points: the falling edge before the expected one, the rising edge just before it, and the expected edge itself. A pipeline that is one stage short or long, or whose last register sits on the rising edge, fails one of these. It also checks that the flag drops one falling edge after a lone trip, which a sticky flag would not do. Finally it offers huge values with valid low, which must neither flag nor disturb the held output.

// File: rtl/orc_pkg.sv
package orc_pkg;
   // Modulator headroom threshold: FS plus FS/32 (about 3.1 %), shift only.
   function automatic int mod_limit(input int fs);
      return fs + (fs >>> 5);
   endfunction
endpackage

// File: rtl/orc_clip.sv
module orc_clip #(
   parameter int W   = 18,
   parameter int LIM = 32767
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_vld,
   input  logic signed [W-1:0] in_dat,
   output logic                out_vld,
   output logic signed [W-1:0] out_dat,
   output logic                trip
);
   localparam logic signed [W:0] POS_L = (W+1)'(LIM);
   localparam logic signed [W:0] NEG_L = -POS_L;

   generate
      if (LIM <= 0 || LIM >= 2**(W-1)) begin : g_bad_lim
         $error("orc_clip: LIM must be positive and fit in W-1 bits");
      end
   endgenerate

   logic signed [W:0]   ext;
   logic                above;
   logic                below;
   logic signed [W-1:0] sat;

   always_comb begin
      ext   = {in_dat[W-1], in_dat};
      above = ext > POS_L;
      below = ext < NEG_L;
      if (above)      sat = POS_L[W-1:0];
      else if (below) sat = NEG_L[W-1:0];
      else            sat = in_dat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_dat <= '0;
         trip    <= 1'b0;
      end else begin
         out_vld <= in_vld;
         trip    <= in_vld & (above | below);
         if (in_vld) out_dat <= sat;
      end
   end
endmodule

// File: rtl/orc_delay.sv
module orc_delay #(
   parameter int DEPTH = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (DEPTH < 0) begin : g_bad_depth
         $error("orc_delay: DEPTH must not be negative");
      end
      if (DEPTH == 0) begin : g_wire
         assign q = d;
      end else begin : g_pipe
         logic [DEPTH-1:0] stg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '0;
            else        stg <= {stg[DEPTH-2 >= 0 ? DEPTH-2 : 0:0], d} >> (DEPTH == 1 ? 0 : 0);
         end
         assign q = stg[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/overrange_clip_pair.sv
module overrange_clip_pair #(
   parameter int MOD_W   = 18,
   parameter int FLT_W   = 18,
   parameter int FS      = 32767,
   parameter int MOD_DLY = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mod_vld,
   input  logic signed [MOD_W-1:0] mod_dat,
   input  logic                    flt_vld,
   input  logic signed [FLT_W-1:0] flt_dat,
   output logic                    mod_clip_vld,
   output logic signed [MOD_W-1:0] mod_clip,
   output logic                    flt_clip_vld,
   output logic signed [FLT_W-1:0] flt_clip,
   output logic                    ovr_flag
);
   localparam int MOD_LIM = orc_pkg::mod_limit(FS);
   localparam int EXTRA   = MOD_DLY - 1;

   generate
      if (MOD_DLY < 1) begin : g_bad_dly
         $error("overrange_clip_pair: MOD_DLY must be at least 1");
      end
      if (MOD_LIM >= 2**(MOD_W-1)) begin : g_bad_modw
         $error("overrange_clip_pair: MOD_W too narrow for headroom limit");
      end
   endgenerate

   logic mod_trip;
   logic flt_trip;
   logic mod_trip_late;

   orc_clip #(.W(MOD_W), .LIM(MOD_LIM)) u_mod_clip (
      .clk(clk), .rst_n(rst_n), .in_vld(mod_vld), .in_dat(mod_dat),
      .out_vld(mod_clip_vld), .out_dat(mod_clip), .trip(mod_trip));

   orc_clip #(.W(FLT_W), .LIM(FS)) u_flt_clip (
      .clk(clk), .rst_n(rst_n), .in_vld(flt_vld), .in_dat(flt_dat),
      .out_vld(flt_clip_vld), .out_dat(flt_clip), .trip(flt_trip));

   orc_delay #(.DEPTH(EXTRA)) u_mod_dly (
      .clk(clk), .rst_n(rst_n), .d(mod_trip), .q(mod_trip_late));

   // Half-cycle stage: flag settles while clock is low.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) ovr_flag <= 1'b0;
      else        ovr_flag <= mod_trip_late | flt_trip;
   end
endmodule

// File: rtl/overrange_clip_pair_chk.sv
module overrange_clip_pair_chk #(
   parameter int MOD_W = 18,
   parameter int FLT_W = 18,
   parameter int FS    = 32767
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    mod_vld,
   input logic signed [MOD_W-1:0] mod_dat,
   input logic                    flt_vld,
   input logic signed [FLT_W-1:0] flt_dat,
   input logic                    mod_clip_vld,
   input logic signed [MOD_W-1:0] mod_clip,
   input logic                    flt_clip_vld,
   input logic signed [FLT_W-1:0] flt_clip,
   input logic                    ovr_flag
);
   localparam int LIM = FS + (FS / 32);

   logic mod_over;
   logic flt_over;
   assign mod_over = mod_vld && (int'(mod_dat) > LIM || int'(mod_dat) < -LIM);
   assign flt_over = flt_vld && (int'(flt_dat) > FS  || int'(flt_dat) < -FS);

   a_r2_mod_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_vld && !mod_over) |=> (mod_clip_vld && mod_clip == $past(mod_dat)));

   a_r3_mod_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      mod_clip_vld |-> (int'(mod_clip) <= LIM && int'(mod_clip) >= -LIM));

   a_r4_flt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      flt_clip_vld |-> (int'(flt_clip) <= FS && int'(flt_clip) >= -FS));

   a_r5_mod_flag: assert property (@(posedge clk) disable iff (!rst_n)
      mod_over |-> ##4 ovr_flag);

   a_r6_flt_flag: assert property (@(posedge clk) disable iff (!rst_n)
      flt_over |=> ovr_flag);

   a_r7_flag_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_flag |-> ($past(flt_over) || $past(mod_over, 4)));
endmodule

bind overrange_clip_pair overrange_clip_pair_chk #(
   .MOD_W(MOD_W), .FLT_W(FLT_W), .FS(FS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mod_vld(mod_vld), .mod_dat(mod_dat),
   .flt_vld(flt_vld), .flt_dat(flt_dat), .mod_clip_vld(mod_clip_vld),
   .mod_clip(mod_clip), .flt_clip_vld(flt_clip_vld), .flt_clip(flt_clip),
   .ovr_flag(ovr_flag)
);

// File: tb/overrange_clip_pair_bench.sv
module overrange_clip_pair_bench;
   localparam int PERIOD = 10;
   localparam int MW = 18;
   localparam int FW = 18;
   localparam int FSV = 32767;
   localparam int MLIM = FSV + FSV / 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mod_vld = 1'b0;
   logic signed [MW-1:0] mod_dat = '0;
   logic flt_vld = 1'b0;
   logic signed [FW-1:0] flt_dat = '0;
   logic mod_clip_vld, flt_clip_vld, ovr_flag;
   logic signed [MW-1:0] mod_clip;
   logic signed [FW-1:0] flt_clip;

   int checks = 0;
   int fails = 0;

   always #(PERIOD/2) clk = ~clk;

   overrange_clip_pair u_overrange_clip_pair (
      .clk(clk), .rst_n(rst_n), .mod_vld(mod_vld), .mod_dat(mod_dat),
      .flt_vld(flt_vld), .flt_dat(flt_dat), .mod_clip_vld(mod_clip_vld),
      .mod_clip(mod_clip), .flt_clip_vld(flt_clip_vld), .flt_clip(flt_clip),
      .ovr_flag(ovr_flag));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int sat(input int v, input int lim);
      if (v > lim)  return lim;
      if (v < -lim) return -lim;
      return v;
   endfunction

   // R2/R3/R5/R7: one modulator sample, flag timing around k+3.5.
   task automatic mod_case(input int v);
      int  ev = sat(v, MLIM);
      int  et = (v != ev) ? 1 : 0;
      @(negedge clk); #1 mod_vld = 1'b1; mod_dat = MW'(v);
      @(posedge clk); #1;
      chk(et ? "R3 mod clip value" : "R2 mod pass value", int'(mod_clip), ev);
      chk("R2 mod out valid", int'(mod_clip_vld), 1);
      @(negedge clk); #1 mod_vld = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk); #2 chk("R5 mod flag not early", int'(ovr_flag), 0);
      @(posedge clk); #1 chk("R5 mod flag low at rising edge", int'(ovr_flag), 0);
      @(negedge clk); #2 chk("R5 mod flag at 3.5 cycles", int'(ovr_flag), et);
      @(negedge clk); #2 chk("R7 flag not sticky", int'(ovr_flag), 0);
   endtask

   // R4/R6/R7: one filter sample.
   task automatic flt_case(input int v);
      int  ev = sat(v, FSV);
      int  et = (v != ev) ? 1 : 0;
      @(negedge clk); #1 flt_vld = 1'b1; flt_dat = FW'(v);
      @(posedge clk); #1;
      chk("R4 flt clip value", int'(flt_clip), ev);
      chk("R4 flt out valid", int'(flt_clip_vld), 1);
      @(negedge clk); #2 chk("R6 flt flag half cycle", int'(ovr_flag), et);
      flt_vld = 1'b0;
      @(negedge clk); #2 chk("R7 flag clears", int'(ovr_flag), 0);
      repeat (4) @(posedge clk);
   endtask

   // R7: modulator trip wins over a concurrent in-range filter sample.
   task automatic or_case();
      @(negedge clk); #1 mod_vld = 1'b1; mod_dat = MW'(50000);
      @(posedge clk);
      @(negedge clk); #1 mod_vld = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk); #1 flt_vld = 1'b1; flt_dat = FW'(123);
      @(posedge clk);
      @(negedge clk); #2 chk("R7 OR keeps mod trip", int'(ovr_flag), 1);
      flt_vld = 1'b0;
      @(negedge clk); #2 chk("R7 OR clears", int'(ovr_flag), 0);
      repeat (4) @(posedge clk);
   endtask

   // R8: invalid samples leave outputs alone and raise nothing.
   task automatic invalid_case();
      int held_m = int'(mod_clip);
      int held_f = int'(flt_clip);
      @(negedge clk); #1 mod_dat = MW'(-90000); flt_dat = FW'(90000);
      @(posedge clk); #1;
      chk("R8 mod held", int'(mod_clip), held_m);
      chk("R8 flt held", int'(flt_clip), held_f);
      chk("R8 mod valid low", int'(mod_clip_vld), 0);
      chk("R8 flt valid low", int'(flt_clip_vld), 0);
      @(negedge clk); #2 chk("R8 no flt flag", int'(ovr_flag), 0);
      @(posedge clk); @(posedge clk); @(posedge clk);
      @(negedge clk); #2 chk("R8 no mod flag", int'(ovr_flag), 0);
      mod_dat = '0; flt_dat = '0;
      repeat (2) @(posedge clk);
   endtask

   initial begin
      #(PERIOD * 200000);
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset mod valid", int'(mod_clip_vld), 0);
      chk("R1 reset mod data", int'(mod_clip), 0);
      chk("R1 reset flt valid", int'(flt_clip_vld), 0);
      chk("R1 reset flt data", int'(flt_clip), 0);
      chk("R1 reset flag", int'(ovr_flag), 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(posedge clk);

      mod_case(1000);
      mod_case(MLIM);
      mod_case(-MLIM);
      mod_case(MLIM + 1);
      mod_case(40000);
      mod_case(-MLIM - 1);
      mod_case(-100000);
      flt_case(100);
      flt_case(FSV);
      flt_case(-FSV);
      flt_case(FSV + 1);
      flt_case(-FSV - 1);
      or_case();
      invalid_case();

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule